// File: doc/BRIEF.md
# Strobed Handshake Input Port

This block receives bytes from a peripheral over a parallel bus that is valid only while the peripheral holds an active-low strobe. The falling edge of the strobe is brought into the host clock domain through a synchronizer. The byte is then captured into a holding register and a buffer-full flag is set. If the host has enabled it, an interrupt request is raised once the strobe has gone high again. The host can instead poll a status register to see that a byte is waiting.

The host reads the held byte through a simple register read strobe. That read empties the buffer and drops the interrupt. On the following clock the block pulses an acknowledge back to the peripheral, which tells the sender it may present the next byte. Because of this exchange, a sender and a receiver running at unrelated rates lose no bytes.

If the sender pulses the strobe again before the host has read the previous byte, the new byte is discarded and a sticky overrun bit records the loss.

Top module: `hs_in_port`

## Requirements
- R1: After reset, buffer-full, overrun, interrupt enable, `irq_o` and `ack_o` are 0 and the status register reads 0.
- R2: A falling edge on `stb_ni` captures `data_i` into the data register and sets buffer-full together with it. Both become visible SYNC_STAGES+1 clock edges after the strobe falls.
- R3: `rdata_o` is combinational on `addr_i`. Address 0 returns the held byte. Address 1 returns status, with bit 0 = buffer-full, bit 1 = overrun, bit 2 = interrupt enable and the other bits 0.
- R4: `irq_o` is 1 exactly when buffer-full is set, interrupt enable is 1 and the synchronized strobe level is high.
- R5: A read (`rd_i`=1 with `addr_i`=0) while buffer-full is set clears buffer-full, and with it `irq_o`, at that clock edge.
- R6: `ack_o` is a one-cycle pulse on the clock after a data read of a full buffer. A data read of an empty buffer, or a status read, gives no pulse.
- R7: A strobe that falls while buffer-full is set is ignored: the held byte is unchanged and overrun is set.
- R8: A write (`wr_i`=1, `addr_i`=1) loads interrupt enable from `wdata_i[0]`. `wdata_i[1]`=1 clears overrun, but an overrun event in the same cycle wins.
- R9: Repeated strobe, read and acknowledge exchanges deliver every byte value 0 to 255 unchanged and in order.
- R10: Status reads and reads with `rd_i`=1 at address 1 do not change buffer-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stb_ni | input | 1 | Peripheral strobe, active low, asynchronous |
| data_i | input | W | Peripheral data, valid around the strobe |
| ack_o | output | 1 | Acknowledge pulse to the peripheral |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| addr_i | input | 1 | Register select: 0 data, 1 status/control |
| wdata_i | input | 2 | Control write data: bit 0 interrupt enable, bit 1 clear overrun |
| rdata_o | output | W | Read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench walks all 256 byte values through complete exchanges and checks each held byte, the acknowledge and the flag state. A design that latched on the wrong edge, or sampled the bus after the strobe rose, would return the scrambled bus value that the bench drives after release. It probes the exact capture latency and the window in which the interrupt must stay low while the strobe is still low. An early interrupt here would invite the host to read before the sender has finished. It also strobes into a full buffer to check that the held byte survives and overrun sets. Finally it reads an empty buffer and the status register, where a careless design would emit a spurious acknowledge and let the sender overwrite data.

// File: rtl/hs_in_pkg.sv
package hs_in_pkg;
  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;

  localparam int unsigned ST_FULL = 0;
  localparam int unsigned ST_OVR  = 1;
  localparam int unsigned ST_IE   = 2;
  localparam int unsigned ST_BITS = 3;
endpackage

// File: rtl/hs_stb_sync.sv
module hs_stb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_ni,
  output logic lvl_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // idle level of the strobe is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], stb_ni};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/hs_capture.sv
module hs_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fall_i,
  input  logic [W-1:0] data_i,
  input  logic         rd_data_i,
  input  logic         clr_ovr_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         ovr_o
);
  logic [W-1:0] data_q;
  logic         full_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (fall_i && !full_q) begin
        data_q <= data_i;
        full_q <= 1'b1;
      end else if (rd_data_i) begin
        full_q <= 1'b0;
      end
      // overrun event wins over a clear in the same cycle
      if (fall_i && full_q) ovr_q <= 1'b1;
      else if (clr_ovr_i)   ovr_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/hs_ack_gen.sv
module hs_ack_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_data_i,
  input  logic full_i,
  output logic ack_o
);
  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= rd_data_i & full_i;
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/hs_in_port.sv
module hs_in_port
  import hs_in_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_ni,
  input  logic [W-1:0] data_i,
  output logic         ack_o,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic         addr_i,
  input  logic [1:0]   wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         irq_o
);
  localparam int unsigned PAD = W - ST_BITS;

  logic         stb_lvl, fall;
  logic         rd_data, wr_ctrl;
  logic [W-1:0] data_q;
  logic         full_q, ovr_q, ie_q;
  reg_sel_e     sel;

  assign sel     = reg_sel_e'(addr_i);
  assign rd_data = rd_i && (sel == SEL_DATA);
  assign wr_ctrl = wr_i && (sel == SEL_CTRL);

  hs_stb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_ni (stb_ni),
    .lvl_o  (stb_lvl),
    .fall_o (fall)
  );

  hs_capture #(.W(W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (fall),
    .data_i    (data_i),
    .rd_data_i (rd_data),
    .clr_ovr_i (wr_ctrl & wdata_i[1]),
    .data_o    (data_q),
    .full_o    (full_q),
    .ovr_o     (ovr_q)
  );

  hs_ack_gen u_ack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_data_i (rd_data),
    .full_i    (full_q),
    .ack_o     (ack_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ie_q <= 1'b0;
    else if (wr_ctrl) ie_q <= wdata_i[0];
  end

  always_comb begin
    if (sel == SEL_DATA) rdata_o = data_q;
    else                 rdata_o = {{PAD{1'b0}}, ie_q, ovr_q, full_q};
  end

  // raise only after the sender has released the strobe
  assign irq_o = full_q & ie_q & stb_lvl;
endmodule

// File: rtl/hs_in_port_chk.sv
module hs_in_port_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         rd_i,
  input logic         addr_i,
  input logic         ack_o,
  input logic         irq_o,
  input logic         fall,
  input logic         full_q,
  input logic         ovr_q,
  input logic         ie_q,
  input logic [W-1:0] data_q
);
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R6
  AST_ACK_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(rd_i && !addr_i && full_q)); // R6
  AST_IRQ_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (full_q && ie_q)); // R4
  AST_READ_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !addr_i && full_q) |=> !full_q); // R5
  AST_HOLD_WHILE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && fall) |=> ($stable(data_q) && ovr_q)); // R7
  AST_CAPTURE_SETS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !full_q) |=> full_q); // R2
endmodule

bind hs_in_port hs_in_port_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rd_i   (rd_i),
  .addr_i (addr_i),
  .ack_o  (ack_o),
  .irq_o  (irq_o),
  .fall   (fall),
  .full_q (full_q),
  .ovr_q  (ovr_q),
  .ie_q   (ie_q),
  .data_q (data_q)
);

// File: tb/sim_hs_in_port.sv
`timescale 1ns/1ps
module sim_hs_in_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         stb_ni = 1'b1;
  logic [W-1:0] data_i = '0;
  logic         ack_o, irq_o;
  logic         rd_i = 1'b0, wr_i = 1'b0, addr_i = 1'b1;
  logic [1:0]   wdata_i = '0;
  logic [W-1:0] rdata_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hs_in_port #(.W(W), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .stb_ni(stb_ni), .data_i(data_i),
    .ack_o(ack_o), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // status sampled at the current negedge, addr left at 1
  task automatic status(input string tag, input logic [31:0] exp);
    addr_i = 1'b1; #1;
    chk(tag, rdata_o, exp);
  endtask

  task automatic ctrl_write(input logic [1:0] v);
    @(negedge clk); wr_i = 1'b1; addr_i = 1'b1; wdata_i = v;
    @(negedge clk); wr_i = 1'b0; wdata_i = '0;
  endtask

  // strobe a byte; exp_full_before is the flag state before capture
  task automatic strobe(input logic [W-1:0] v, input bit was_full, input bit ie);
    @(negedge clk); data_i = v; stb_ni = 1'b0;
    @(negedge clk);
    @(negedge clk); #1;
    chk("R2 no capture before sync latency", rdata_o[0], 32'(was_full));
    @(negedge clk); #1;
    chk("R2 full after sync latency", rdata_o[0], 32'd1);
    chk("R4 irq low while strobe low", irq_o, 32'd0);
    stb_ni = 1'b1; data_i = ~v;
    @(negedge clk);
    @(negedge clk); #1;
    chk("R4 irq after strobe release", irq_o, 32'(ie));
  endtask

  task automatic read_data(input string tag, input logic [W-1:0] exp, input bit exp_ack);
    @(negedge clk); addr_i = 1'b0; rd_i = 1'b1; #1;
    chk({tag, " R3 data value"}, rdata_o, 32'(exp));
    @(negedge clk); rd_i = 1'b0; addr_i = 1'b1; #1;
    chk({tag, " R6 ack pulse"}, ack_o, 32'(exp_ack));
    chk("R5 full cleared", rdata_o[0], 32'd0);
    chk("R5 irq cleared", irq_o, 32'd0);
    @(negedge clk); #1;
    chk("R6 ack one cycle", ack_o, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    status("R1 status after reset", 32'd0);
    chk("R1 irq after reset", irq_o, 32'd0);
    chk("R1 ack after reset", ack_o, 32'd0);

    // R6 read of empty buffer: no ack
    read_data("R6 empty read", 8'h00, 1'b0);

    // R8 enable interrupts
    ctrl_write(2'b01);
    #1; chk("R8 ie set", rdata_o, 32'h4);

    // R9 sweep all byte values with interrupt enabled
    for (int v = 0; v < 256; v++) begin
      strobe(v[W-1:0], 1'b0, 1'b1);
      read_data("R9 sweep", v[W-1:0], 1'b1);
    end

    // R7 overrun: strobe while full
    strobe(8'hA5, 1'b0, 1'b1);
    strobe(8'h3C, 1'b1, 1'b1);
    status("R7 overrun flag", 32'h7);
    // R10 status reads with rd do not disturb full
    @(negedge clk); rd_i = 1'b1; addr_i = 1'b1;
    @(negedge clk); rd_i = 1'b0; #1;
    chk("R10 full kept", rdata_o, 32'h7);
    chk("R10 no ack on status read", ack_o, 32'd0);
    read_data("R7 held byte", 8'hA5, 1'b1);
    status("R7 overrun sticky", 32'h6);

    // R8 clear overrun and disable interrupt
    ctrl_write(2'b10);
    #1; chk("R8 overrun cleared ie off", rdata_o, 32'h0);

    // R4 no irq with enable off
    strobe(8'h5A, 1'b0, 1'b0);
    chk("R4 irq off when disabled", irq_o, 32'd0);
    ctrl_write(2'b01);
    #1; chk("R4 irq on when enabled later", irq_o, 32'd1);
    read_data("R4 final", 8'h5A, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule